// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects a set of interrupt request lines (64 by default) and presents one encoded request level to the processor. Software gives every line a priority level from 0 to 7 through a small write port. The block then tracks which line is pending, enabled and unmasked, picks the strongest one, and drives that line's level on a 3-bit output. Level 7 is the most urgent, and a value of 0 means nothing is requesting.

When the processor takes the interrupt, it runs an acknowledge. This can be a one-cycle hardware strobe, or a read of a dedicated address on the register read port. Both forms return the same 8-bit vector. The vector is unique to the winning line, and a fixed spurious value comes back when no line is requesting.

Requests are not stored. A line counts only while its input is held high. A wake-up output shows that at least one unmasked request is present, so the system can leave a stopped clock state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `ipl_out` is 0 and `wake_out` is 0. All levels are 0 and every per-line mask is set. A hardware acknowledge returns the spurious vector 24.
- R2: `ipl_out` equals the highest level among the lines whose input is high, whose level is nonzero and which are not masked.
- R3: If several qualifying lines share the highest level, the acknowledge vector is that of the lowest-numbered one. Line n has vector 64+n.
- R4: A line whose level register holds 0 never requests, even while its input is high.
- R5: Writing 1 to a line's mask bit stops that line from requesting. Writing 0 lets it request again. The mask write address is 0x40+n, and the mask value is `wr_data[0]`.
- R6: When the global mask bit is set, `ipl_out` is 0 and `wake_out` is 0. The global mask write address is 0x80, with the value in `wr_data[0]`. The level write address is 0x00+n, with the value in `wr_data[2:0]`.
- R7: A request is not latched. Once the input falls, that line no longer counts.
- R8: A one-cycle `iack` pulse gives `ack_valid` high for exactly one cycle, on the cycle after the pulse. During that cycle `ack_vec` holds the winning vector, or 24 if no line is requesting.
- R9: A read at address 0xC0 returns on `rd_data` the same vector as a hardware acknowledge. A read at address n returns line n's level in bits [2:0]. Read data appears one cycle after `rd_en`.
- R10: `wake_out` is high exactly when `ipl_out` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Request lines, active high, level sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address: [7:6] selects the bank, [5:0] selects the line |
| wr_data | input | 3 | Write data: a level, or a mask value in bit 0 |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read address: [7:6]=00 reads a level, 11 reads the acknowledge |
| rd_data | output | 8 | Registered read data |
| iack | input | 1 | Hardware acknowledge strobe |
| ack_valid | output | 1 | Vector valid, one cycle after `iack` |
| ack_vec | output | 8 | Acknowledge vector |
| ipl_out | output | 3 | Encoded request level to the processor |
| wake_out | output | 1 | Unmasked request present |

## Verification
The bench targets ties at the top level. Two lines share level 4, and a design that scans in the wrong direction would return the higher-numbered vector. It raises a line whose level is 0, which a design that treats level 0 as enabled would answer with a nonzero request. It also toggles the per-line and global masks, which a wrongly decoded mask bank would ignore. Finally, it drops every input after a request, which a design that latched requests would keep reporting, and it compares the software and hardware acknowledge vectors, which would expose any drift between the two paths.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Bank select carried in the top two address bits
  typedef enum logic [1:0] {
    BANK_LVL  = 2'b00,
    BANK_MASK = 2'b01,
    BANK_GLOB = 2'b10,
    BANK_ACK  = 2'b11
  } bank_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int AW     = IDX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [LVL_W-1:0]         wr_data,
  output logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic [NUM_SRC-1:0]       mask_o,
  output logic                     gmask_o
);
  bank_sel_e        bank;
  logic [IDX_W-1:0] idx;

  assign bank = bank_sel_e'(wr_addr[AW-1:AW-2]);
  assign idx  = wr_addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_flat[g*LVL_W +: LVL_W] <= '0;
        mask_o[g]                  <= 1'b1;
      end else if (wr_en && idx == IDX_W'(g)) begin
        if (bank == BANK_LVL)  lvl_flat[g*LVL_W +: LVL_W] <= wr_data;
        if (bank == BANK_MASK) mask_o[g] <= wr_data[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            gmask_o <= 1'b0;
    else if (wr_en && bank == BANK_GLOB) gmask_o <= wr_data[0];
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_SRC = 64,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       irq_in,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  input  logic [NUM_SRC-1:0]       mask_i,
  input  logic                     gmask_i,
  output logic [LVL_W-1:0]         lvl_q,
  output logic [IDX_W-1:0]         idx_q,
  output logic                     any_q
);
  logic [LVL_W-1:0] eff [NUM_SRC];
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;

  // Effective level: zero unless the line is high, unmasked and globally open
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_eff
    assign eff[g] = (irq_in[g] && !mask_i[g] && !gmask_i)
                    ? lvl_flat[g*LVL_W +: LVL_W] : '0;
  end

  // Downward scan with >= so the lowest index wins a tie
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eff[i] != '0 && eff[i] >= best_lvl) begin
        best_lvl = eff[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      idx_q <= '0;
      any_q <= 1'b0;
    end else begin
      lvl_q <= best_lvl;
      idx_q <= best_idx;
      any_q <= (best_lvl != '0);
    end
  end

  // R6
  gmask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(gmask_i) |-> (lvl_q == '0 && !any_q));
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int AW      = IDX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     any_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  input  logic                     iack,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  output logic [VEC_W-1:0]         rd_data,
  output logic                     ack_valid,
  output logic [VEC_W-1:0]         ack_vec
);
  logic [VEC_W-1:0] cur_vec;
  bank_sel_e        rbank;
  logic [IDX_W-1:0] ridx;

  assign cur_vec = any_i ? (VEC_W'(VEC_BASE) + VEC_W'(idx_i)) : VEC_W'(SPUR_VEC);
  assign rbank   = bank_sel_e'(rd_addr[AW-1:AW-2]);
  assign ridx    = rd_addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid <= 1'b0;
      ack_vec   <= VEC_W'(SPUR_VEC);
      rd_data   <= '0;
    end else begin
      ack_valid <= iack;
      if (iack) ack_vec <= cur_vec;
      if (rd_en) begin
        case (rbank)
          BANK_LVL: rd_data <= VEC_W'(lvl_flat[ridx*LVL_W +: LVL_W]);
          BANK_ACK: rd_data <= cur_vec;
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  // R8
  ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
    iack |=> ack_valid);
  // R3
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (int'(ack_vec) == SPUR_VEC ||
                   (int'(ack_vec) >= VEC_BASE && int'(ack_vec) < VEC_BASE + NUM_SRC)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC  = 64,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int AW      = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [LVL_W-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [VEC_W-1:0]   rd_data,
  input  logic               iack,
  output logic               ack_valid,
  output logic [VEC_W-1:0]   ack_vec,
  output logic [LVL_W-1:0]   ipl_out,
  output logic               wake_out
);
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic [NUM_SRC-1:0]       mask_w;
  logic                     gmask_w;
  logic [IDX_W-1:0]         win_idx;
  logic                     win_any;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lvl_flat(lvl_flat), .mask_o(mask_w), .gmask_o(gmask_w)
  );

  irq_prio_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) arb_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .lvl_flat(lvl_flat),
    .mask_i(mask_w), .gmask_i(gmask_w),
    .lvl_q(ipl_out), .idx_q(win_idx), .any_q(win_any)
  );

  irq_vec_unit #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
                 .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)) vec_i (
    .clk(clk), .rst(rst), .any_i(win_any), .idx_i(win_idx), .lvl_flat(lvl_flat),
    .iack(iack), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ack_valid(ack_valid), .ack_vec(ack_vec)
  );

  assign wake_out = win_any;

  // R10
  wake_ipl_chk: assert property (@(posedge clk) disable iff (rst)
    wake_out == (ipl_out != '0));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [2:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        iack = 1'b0;
  logic        ack_valid;
  logic [7:0]  ack_vec;
  logic [2:0]  ipl_out;
  logic        wake_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef enum int {K_IPL, K_WAKE, K_VEC, K_VALID, K_RD} kind_e;
  typedef struct { kind_e kind; int exp; string req; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .iack(iack), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .ipl_out(ipl_out), .wake_out(wake_out)
  );

  task automatic push(kind_e k, int e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  // Monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (sb.size() != 0);
      #1;
      while (sb.size() != 0) begin
        item_t it;
        int act;
        it = sb.pop_front();
        case (it.kind)
          K_IPL:   act = int'(ipl_out);
          K_WAKE:  act = int'(wake_out);
          K_VEC:   act = int'(ack_vec);
          K_VALID: act = int'(ack_valid);
          default: act = int'(rd_data);
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s kind=%s actual=%0d expected=%0d", it.req, it.kind.name(), act, it.exp);
        end
      end
    end
  end

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hw_ack(int exp_vec, string r);
    @(negedge clk);
    iack = 1'b1;
    @(negedge clk);
    iack = 1'b0;
    push(K_VALID, 1, r);
    push(K_VEC, exp_vec, r);
    @(negedge clk);
    push(K_VALID, 0, r);
  endtask

  task automatic rd(input logic [7:0] a, int exp, string r);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    push(K_RD, exp, r);
  endtask

  task automatic expect_lvl(int lvl, string r);
    settle();
    push(K_IPL, lvl, r);
    push(K_WAKE, (lvl != 0) ? 1 : 0, "R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    push(K_IPL, 0, "R1");
    push(K_WAKE, 0, "R1");
    hw_ack(24, "R1");

    for (int i = 0; i < 64; i++) wr(8'h40 | 8'(i), 3'd0);
    wr(8'd3, 3'd2);
    wr(8'd40, 3'd6);
    wr(8'd5, 3'd4);
    wr(8'd9, 3'd4);
    wr(8'd63, 3'd7);

    // R2 single line
    irq_in = '0; irq_in[3] = 1'b1;
    expect_lvl(2, "R2");
    hw_ack(67, "R8");

    // R2 higher level wins; R9 software acknowledge
    irq_in[40] = 1'b1;
    expect_lvl(6, "R2");
    rd(8'hC0, 104, "R9");
    hw_ack(104, "R8");

    // R3 tie at level 4
    irq_in = '0; irq_in[9] = 1'b1; irq_in[5] = 1'b1; irq_in[3] = 1'b1;
    expect_lvl(4, "R3");
    hw_ack(69, "R3");
    rd(8'hC0, 69, "R3");

    // R4 level 0 line
    irq_in = '0; irq_in[12] = 1'b1;
    expect_lvl(0, "R4");
    hw_ack(24, "R4");

    // R5 per-line mask
    irq_in = '0; irq_in[3] = 1'b1; irq_in[40] = 1'b1;
    wr(8'h40 | 8'd40, 3'd1);
    expect_lvl(2, "R5");
    hw_ack(67, "R5");
    wr(8'h40 | 8'd40, 3'd0);
    expect_lvl(6, "R5");

    // R6 global mask
    irq_in[63] = 1'b1;
    wr(8'h80, 3'd1);
    expect_lvl(0, "R6");
    hw_ack(24, "R6");
    wr(8'h80, 3'd0);
    expect_lvl(7, "R6");
    hw_ack(127, "R6");

    // R7 no latching
    irq_in = '0;
    expect_lvl(0, "R7");
    rd(8'hC0, 24, "R7");
    irq_in[5] = 1'b1;
    expect_lvl(4, "R7");
    irq_in = '0;
    expect_lvl(0, "R7");

    // R9 level readback
    rd(8'd40, 6, "R9");
    rd(8'd9, 4, "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule